// File: doc/BRIEF.md
# Four-Channel Reloading Interval Timer Bank

This block holds a bank of independent down-counting timers behind one word-addressed register port. Software writes a reload value and sets the enable bit of a channel. The channel then counts down by one on every clock. When the count reaches zero, the channel sets its expiry flag and takes the reload value again, so that it produces a periodic tick with no further software work. A bank-wide stop bit freezes every channel at once. A channel can be told to count expiries of the channel below it instead of clocks, which lets two 32-bit channels act as one 64-bit timer. A single interrupt line combines the flags of the channels whose interrupt is enabled.

Each channel is a small state machine with three named states. CH_IDLE means the channel is disabled and holds its count. CH_COUNT means it is enabled and the bank is running. CH_FROZEN means it is enabled but the bank stop bit is set. The transitions are as follows. ENABLE_RISE goes from CH_IDLE to CH_COUNT, or to CH_FROZEN when the bank is stopped, and loads the count from the reload register. DISABLE goes from any state to CH_IDLE. BANK_STOP goes from CH_COUNT to CH_FROZEN. BANK_RESUME goes from CH_FROZEN to CH_COUNT. Inside CH_COUNT, STEP decrements the count and EXPIRE reloads it and sets the flag.

Top module: `intv_timer_bank`

## Requirements
- R1: After reset every register reads zero (bank control, reload values, current values, channel controls, flags) and irq is low.
- R2: A write that changes the enable bit (control bit 0) from 0 to 1 makes the current value equal the reload value right after that write's clock edge. From then on, an unchained running channel decrements by one per clock.
- R3: In the clock where a running channel's count is zero, the channel reloads from its reload register and sets flag bit 0. A period therefore lasts reload+1 clocks and repeats with no software action; a reload value of 1 gives a period of 2.
- R4: Writing the reload register while the channel runs leaves the current count and its decrement untouched. The new value is used at the next reload.
- R5: A channel whose enable bit is 0 holds its current value. Clearing the enable bit and then setting it again restarts the count from the reload value.
- R6: Bit 1 of the bank control register at offset 0x000 stops all channels: their current values hold while it is 1, and counting resumes from the held value when it is cleared. Only bit 1 of that register is stored and read back.
- R7: Writing a 1 to bit 0 of a channel's flag register clears the flag. Writing 0 leaves it unchanged.
- R8: When a flag-clear write and an expiry of the same channel fall in the same clock, the flag ends up set.
- R9: When control bit 2 (chain) is set on channel n > 0, channel n decrements and expires only in clocks where channel n-1 expires. Bit 2 has no effect on channel 0.
- R10: irq is 1 exactly when some channel has both its flag and its interrupt enable (control bit 1) set. The flag itself is set and readable whether or not the interrupt enable is set.
- R11: Channel n occupies 0x100 + 0x10*n, with the reload value at +0x0, the current value at +0x4, control at +0x8 and flag at +0xC. Any other offset, including misaligned ones and the slot above the last channel, reads zero and ignores writes. The current value register cannot be written.
- R12: A channel control register stores and returns only bits 2:0; the higher bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all counting and register updates happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe; wdata is stored at addr on the rising edge |
| addr | input | ADDR_W (12) | Byte address of the register being read or written |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for addr, combinational |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can act on a flag in the same clock: an expiry that sets it, and a software write of 1 that clears it. The bench starts a channel with a short reload value and counts the clocks from the enabling edge. It then times a flag-clear write so that its edge is the one where the count passes through zero. The result counts as correct only if the flag still reads 1 and the count has reloaded. The same timing-based method is used for a reload write issued mid-period and for the chained channel, whose steps must fall exactly on the lower channel's expiry edges.

// File: rtl/itb_pkg.sv
package itb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_COUNT  = 2'd1,
        CH_FROZEN = 2'd2
    } ch_state_e;

    // register layout inside one channel slot (word index)
    localparam logic [1:0] SLOT_RELOAD = 2'd0;
    localparam logic [1:0] SLOT_CUR    = 2'd1;
    localparam logic [1:0] SLOT_CTRL   = 2'd2;
    localparam logic [1:0] SLOT_FLAG   = 2'd3;

    localparam int SLOT_BYTES = 16;

    localparam int CTL_RUN   = 0;
    localparam int CTL_IRQEN = 1;
    localparam int CTL_LINK  = 2;
    localparam int CTL_W     = 3;

    localparam int BANK_STOP_BIT = 1;

endpackage

// File: rtl/itb_channel.sv
module itb_channel
    import itb_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int DATA_W   = 32,
    parameter bit HAS_PREV = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stop_next,
    input  logic              prev_expire,
    input  logic              reload_we,
    input  logic              ctrl_we,
    input  logic              flag_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CTL_W-1:0]  ctrl_o,
    output logic              flag_o,
    output logic              expire_o
);

    ch_state_e         state_q, state_d;
    logic [CNT_W-1:0]  count_q, reload_q;
    logic [CTL_W-1:0]  ctrl_q;
    logic              flag_q;
    logic              run_next, start, stop_wr, linked, step, expire;

    assign run_next = ctrl_we ? wdata[CTL_RUN] : ctrl_q[CTL_RUN];
    assign start    = ctrl_we && wdata[CTL_RUN] && !ctrl_q[CTL_RUN];
    assign stop_wr  = ctrl_we && !wdata[CTL_RUN];
    assign linked   = HAS_PREV && ctrl_q[CTL_LINK];
    assign step     = linked ? prev_expire : 1'b1;
    assign expire   = (state_q == CH_COUNT) && !stop_wr && step && (count_q == '0);

    // next-state selection
    always_comb begin
        if (!run_next)      state_d = CH_IDLE;
        else if (stop_next) state_d = CH_FROZEN;
        else                state_d = CH_COUNT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // counter driven by the current state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            unique case (state_q)
                CH_IDLE: begin
                    if (start) count_q <= reload_q;
                end
                CH_COUNT: begin
                    if (expire)                 count_q <= reload_q;
                    else if (!stop_wr && step)  count_q <= count_q - 1'b1;
                end
                CH_FROZEN: begin
                    count_q <= count_q;
                end
                default: begin
                    count_q <= count_q;
                end
            endcase
        end
    end

    // software-visible registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            flag_q   <= 1'b0;
        end else begin
            if (reload_we) reload_q <= wdata[CNT_W-1:0];
            if (ctrl_we)   ctrl_q   <= wdata[CTL_W-1:0];
            if (expire)                       flag_q <= 1'b1;
            else if (flag_we && wdata[0])     flag_q <= 1'b0;
        end
    end

    assign count_o  = count_q;
    assign reload_o = reload_q;
    assign ctrl_o   = ctrl_q;
    assign flag_o   = flag_q;
    assign expire_o = expire;

endmodule

// File: rtl/itb_regif.sv
module itb_regif
    import itb_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 32,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter int unsigned CH_BASE = 'h100
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr_stop_bit,
    output logic [DATA_W-1:0]            rdata,
    output logic                         stop_q,
    output logic                         stop_next,
    output logic [NUM_CH-1:0]            reload_we,
    output logic [NUM_CH-1:0]            ctrl_we,
    output logic [NUM_CH-1:0]            flag_we,
    input  logic [NUM_CH-1:0][CNT_W-1:0] count_i,
    input  logic [NUM_CH-1:0][CNT_W-1:0] reload_i,
    input  logic [NUM_CH-1:0][CTL_W-1:0] ctrl_i,
    input  logic [NUM_CH-1:0]            flag_i
);

    localparam int IDX_LSB  = $clog2(SLOT_BYTES);
    localparam int IDX_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_SIZE = NUM_CH * SLOT_BYTES;

    logic [ADDR_W-1:0] rel;
    logic              ch_hit, bank_hit, bank_we;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        slot;

    assign rel      = addr - ADDR_W'(CH_BASE);
    assign ch_hit   = (rel < ADDR_W'(WIN_SIZE)) && (rel[1:0] == 2'b00);
    assign idx      = rel[IDX_LSB +: IDX_W];
    assign slot     = rel[3:2];
    assign bank_hit = (addr == '0);
    assign bank_we  = wr_en && bank_hit;

    always_ff @(posedge clk) begin
        if (!rst_n)       stop_q <= 1'b0;
        else if (bank_we) stop_q <= wr_stop_bit;
    end

    assign stop_next = bank_we ? wr_stop_bit : stop_q;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_we
        logic sel;
        assign sel          = wr_en && ch_hit && (idx == IDX_W'(i));
        assign reload_we[i] = sel && (slot == SLOT_RELOAD);
        assign ctrl_we[i]   = sel && (slot == SLOT_CTRL);
        assign flag_we[i]   = sel && (slot == SLOT_FLAG);
    end

    always_comb begin
        rdata = '0;
        if (bank_hit) begin
            rdata[BANK_STOP_BIT] = stop_q;
        end else if (ch_hit) begin
            unique case (slot)
                SLOT_RELOAD: rdata[CNT_W-1:0] = reload_i[idx];
                SLOT_CUR:    rdata[CNT_W-1:0] = count_i[idx];
                SLOT_CTRL:   rdata[CTL_W-1:0] = ctrl_i[idx];
                SLOT_FLAG:   rdata[0]         = flag_i[idx];
                default:     rdata            = '0;
            endcase
        end
    end

endmodule

// File: rtl/intv_timer_bank.sv
module intv_timer_bank
    import itb_pkg::*;
#(
    parameter int          NUM_CH  = 4,
    parameter int          CNT_W   = 32,
    parameter int          DATA_W  = 32,
    parameter int          ADDR_W  = 12,
    parameter int unsigned CH_BASE = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    logic [NUM_CH-1:0][CNT_W-1:0] count_arr, reload_arr;
    logic [NUM_CH-1:0][CTL_W-1:0] ctrl_arr;
    logic [NUM_CH-1:0]            flag_arr, expire_arr, prev_exp;
    logic [NUM_CH-1:0]            reload_we, ctrl_we, flag_we;
    logic                         stop_q, stop_next;

    itb_regif #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .CH_BASE(CH_BASE)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_stop_bit(wdata[BANK_STOP_BIT]),
        .rdata      (rdata),
        .stop_q     (stop_q),
        .stop_next  (stop_next),
        .reload_we  (reload_we),
        .ctrl_we    (ctrl_we),
        .flag_we    (flag_we),
        .count_i    (count_arr),
        .reload_i   (reload_arr),
        .ctrl_i     (ctrl_arr),
        .flag_i     (flag_arr)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        if (i == 0) begin : g_first
            assign prev_exp[i] = 1'b0;
        end else begin : g_next
            assign prev_exp[i] = expire_arr[i-1];
        end

        itb_channel #(
            .CNT_W   (CNT_W),
            .DATA_W  (DATA_W),
            .HAS_PREV(i > 0)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .stop_next  (stop_next),
            .prev_expire(prev_exp[i]),
            .reload_we  (reload_we[i]),
            .ctrl_we    (ctrl_we[i]),
            .flag_we    (flag_we[i]),
            .wdata      (wdata),
            .count_o    (count_arr[i]),
            .reload_o   (reload_arr[i]),
            .ctrl_o     (ctrl_arr[i]),
            .flag_o     (flag_arr[i]),
            .expire_o   (expire_arr[i])
        );
    end

    always_comb begin
        irq = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            irq = irq | (flag_arr[i] & ctrl_arr[i][CTL_IRQEN]);
        end
    end

endmodule

// File: rtl/itb_chk.sv
module itb_chk
    import itb_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         stop_q,
    input logic [NUM_CH-1:0]            reload_we,
    input logic [NUM_CH-1:0]            ctrl_we,
    input logic [NUM_CH-1:0]            flag_we,
    input logic [DATA_W-1:0]            wdata,
    input logic [NUM_CH-1:0][CNT_W-1:0] count_arr,
    input logic [NUM_CH-1:0][CNT_W-1:0] reload_arr,
    input logic [NUM_CH-1:0][CTL_W-1:0] ctrl_arr,
    input logic [NUM_CH-1:0]            flag_arr,
    input logic [NUM_CH-1:0]            expire_arr,
    input logic                         irq
);

    // R10
    quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_arr == '0) |-> !irq);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R2
        start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctrl_we[i] && wdata[CTL_RUN] && !ctrl_arr[i][CTL_RUN])
            |=> (count_arr[i] == $past(reload_arr[i])));

        // R3
        expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            expire_arr[i] |=> (count_arr[i] == $past(reload_arr[i])) && flag_arr[i]);

        // R5
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ctrl_arr[i][CTL_RUN] && !ctrl_we[i]) |=> $stable(count_arr[i]));

        // R6
        bank_stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_q && !ctrl_we[i]) |=> $stable(count_arr[i]));

        // R7
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_we[i] && wdata[0] && !expire_arr[i]) |=> !flag_arr[i]);

        // R7
        flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!expire_arr[i] && !(flag_we[i] && wdata[0])) |=> $stable(flag_arr[i]));

        // R8
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (expire_arr[i] && flag_we[i]) |=> flag_arr[i]);

        if (i == 0) begin : g_free
            // R4
            reload_wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (reload_we[i] && ctrl_arr[i][CTL_RUN] && !stop_q && (count_arr[i] != '0))
                |=> (count_arr[i] == $past(count_arr[i]) - 1'b1));
        end else begin : g_linked
            // R9
            link_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_arr[i][CTL_LINK] && !expire_arr[i-1] && !ctrl_we[i])
                |=> $stable(count_arr[i]));
        end
    end

endmodule

bind intv_timer_bank itb_chk #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_q    (stop_q),
    .reload_we (reload_we),
    .ctrl_we   (ctrl_we),
    .flag_we   (flag_we),
    .wdata     (wdata),
    .count_arr (count_arr),
    .reload_arr(reload_arr),
    .ctrl_arr  (ctrl_arr),
    .flag_arr  (flag_arr),
    .expire_arr(expire_arr),
    .irq       (irq)
);

// File: tb/intv_timer_bank_tb.sv
module intv_timer_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    intv_timer_bank u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    localparam int RG_LD = 0, RG_CUR = 1, RG_CTL = 2, RG_FLG = 3;

    function automatic logic [11:0] ra(input int ch, input int r);
        return 12'(32'h100 + ch * 16 + r * 4);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        chk(tag, rdata, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_chk("R1 bank ctrl", 12'h000, 0);
        for (int c = 0; c < 4; c++) begin
            rd_chk("R1 reload", ra(c, RG_LD), 0);
            rd_chk("R1 current", ra(c, RG_CUR), 0);
            rd_chk("R1 ctrl", ra(c, RG_CTL), 0);
            rd_chk("R1 flag", ra(c, RG_FLG), 0);
        end
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_count_reload();
        bus_wr(ra(0, RG_LD), 5);
        bus_wr(ra(0, RG_CTL), 1);
        rd_chk("R2 load on enable", ra(0, RG_CUR), 5);
        wait_cyc(3);
        rd_chk("R2 decrement", ra(0, RG_CUR), 2);
        wait_cyc(2);
        rd_chk("R3 at zero", ra(0, RG_CUR), 0);
        rd_chk("R3 flag not yet", ra(0, RG_FLG), 0);
        wait_cyc(1);
        rd_chk("R3 reloaded", ra(0, RG_CUR), 5);
        rd_chk("R3 flag set", ra(0, RG_FLG), 1);
        chk("R10 no irq without enable", {31'd0, irq}, 0);
        wait_cyc(6);
        rd_chk("R3 periodic", ra(0, RG_CUR), 5);
    endtask

    task automatic t_flag_irq();
        bus_wr(ra(0, RG_CTL), 32'hFFFF_FFFA);
        rd_chk("R12 ctrl bits", ra(0, RG_CTL), 2);
        chk("R10 irq on", {31'd0, irq}, 1);
        bus_wr(ra(0, RG_FLG), 0);
        rd_chk("R7 write 0 keeps", ra(0, RG_FLG), 1);
        bus_wr(ra(0, RG_FLG), 1);
        rd_chk("R7 write 1 clears", ra(0, RG_FLG), 0);
        chk("R10 irq off", {31'd0, irq}, 0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        addr = ra(0, RG_CUR);
        #1;
        v = rdata;
        wait_cyc(10);
        rd_chk("R5 disabled holds", ra(0, RG_CUR), v);
    endtask

    task automatic t_reload_write();
        bus_wr(ra(0, RG_LD), 9);
        bus_wr(ra(0, RG_CTL), 1);
        rd_chk("R2 start", ra(0, RG_CUR), 9);
        wait_cyc(2);
        rd_chk("R2 count", ra(0, RG_CUR), 7);
        bus_wr(ra(0, RG_LD), 100);
        rd_chk("R4 count undisturbed", ra(0, RG_CUR), 6);
        wait_cyc(6);
        rd_chk("R4 old period ends", ra(0, RG_CUR), 0);
        wait_cyc(1);
        rd_chk("R4 new reload used", ra(0, RG_CUR), 100);
    endtask

    task automatic t_restart_stop();
        logic [31:0] v;
        bus_wr(ra(0, RG_LD), 20);
        bus_wr(ra(0, RG_CTL), 0);
        addr = ra(0, RG_CUR);
        #1;
        v = rdata;
        wait_cyc(4);
        rd_chk("R5 hold after disable", ra(0, RG_CUR), v);
        bus_wr(ra(0, RG_CTL), 1);
        rd_chk("R5 restart from reload", ra(0, RG_CUR), 20);
        bus_wr(12'h000, 32'hFFFF_FFFF);
        rd_chk("R6 only stop bit stored", 12'h000, 2);
        rd_chk("R6 last step", ra(0, RG_CUR), 19);
        wait_cyc(5);
        rd_chk("R6 frozen", ra(0, RG_CUR), 19);
        bus_wr(12'h000, 0);
        rd_chk("R6 resume edge", ra(0, RG_CUR), 19);
        wait_cyc(3);
        rd_chk("R6 resumed", ra(0, RG_CUR), 16);
    endtask

    task automatic t_chain();
        bus_wr(ra(0, RG_CTL), 0);
        bus_wr(ra(0, RG_FLG), 1);
        bus_wr(ra(1, RG_LD), 1);
        bus_wr(ra(1, RG_CTL), 5);
        rd_chk("R9 upper start", ra(1, RG_CUR), 1);
        bus_wr(ra(0, RG_LD), 2);
        bus_wr(ra(0, RG_CTL), 5);
        rd_chk("R9 upper waits", ra(1, RG_CUR), 1);
        wait_cyc(3);
        rd_chk("R9 ch0 link ignored", ra(0, RG_FLG), 1);
        rd_chk("R9 upper stepped", ra(1, RG_CUR), 0);
        rd_chk("R9 upper no flag", ra(1, RG_FLG), 0);
        wait_cyc(2);
        rd_chk("R9 upper still", ra(1, RG_CUR), 0);
        wait_cyc(1);
        rd_chk("R9 upper reload", ra(1, RG_CUR), 1);
        rd_chk("R9 upper flag", ra(1, RG_FLG), 1);
    endtask

    task automatic t_collide();
        bus_wr(ra(2, RG_LD), 3);
        bus_wr(ra(2, RG_CTL), 1);
        wait_cyc(3);
        rd_chk("R8 before expiry", ra(2, RG_CUR), 0);
        bus_wr(ra(2, RG_FLG), 1);
        rd_chk("R8 set wins", ra(2, RG_FLG), 1);
        rd_chk("R8 reloaded", ra(2, RG_CUR), 3);
    endtask

    task automatic t_min_period();
        bus_wr(ra(3, RG_CUR), 55);
        rd_chk("R11 current read-only", ra(3, RG_CUR), 0);
        bus_wr(ra(3, RG_LD), 1);
        bus_wr(ra(3, RG_CTL), 1);
        wait_cyc(1);
        rd_chk("R3 min zero", ra(3, RG_CUR), 0);
        rd_chk("R3 min no flag", ra(3, RG_FLG), 0);
        wait_cyc(1);
        rd_chk("R3 min reload", ra(3, RG_CUR), 1);
        rd_chk("R3 min flag", ra(3, RG_FLG), 1);
    endtask

    task automatic t_addr_map();
        bus_wr(12'h004, 32'hFFFF_FFFF);
        rd_chk("R11 hole reads 0", 12'h004, 0);
        rd_chk("R11 bank untouched", 12'h000, 0);
        bus_wr(12'h140, 32'hFFFF_FFFF);
        rd_chk("R11 above window", 12'h140, 0);
        bus_wr(12'h101, 32'hFFFF_FFFF);
        rd_chk("R11 misaligned ignored", ra(0, RG_LD), 2);
        rd_chk("R11 misaligned read", 12'h101, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count_reload();
        t_flag_irq();
        t_hold();
        t_reload_write();
        t_restart_stop();
        t_chain();
        t_collide();
        t_min_period();
        t_addr_map();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

endmodule